// File: doc/BRIEF.md
# Burst Address and Cycle Control

This block sits at the front of a synchronous burst SRAM and turns the per-cycle control inputs into one array operation per clock. Each rising edge classifies the cycle as one of four kinds: a burst start at the external address, a step to the next burst address, a pause on the current address, or a deselect. The block then registers the array address, a command code and the per-byte write strobes for that cycle.

There are two active-low address strobes. The processor strobe always starts a read, and the primary chip select masks it. The controller strobe starts either a read or a write, depending on the write inputs. Only the two low address bits are counted inside a burst. They can follow a linear or an interleaved sequence.

Top module: `burst_front_ctrl`

## Requirements
- R1: Under synchronous active-high reset the outputs are address 0, command IDLE (code 0) and all write strobes 0.
- R2: The processor strobe is low, the primary select is low and the secondary selects are true (high select 1, low select 0). The next outputs are then command READ (code 1) at the external address with strobes 0, whatever the write inputs are, and even when the controller strobe is also low.
- R3: When the primary select is high, a low processor strobe is ignored. With the controller strobe high, the cycle acts as a step or a pause of the running burst.
- R4: The controller strobe is low, the processor strobe is high and the chip is fully selected. A burst then starts at the external address. The command is WRITE (code 2) when the write inputs request a write and READ otherwise.
- R5: The result is a deselect (command IDLE, counter unchanged) in two cases: the controller strobe is low while the primary select is high, or a strobe is active while the secondary selects are false. After a deselect, advance cycles stay IDLE until a new start. The secondary selects are ignored when both strobes are high.
- R6: With the order select low at burst start, the low two address bits step as start+k modulo 4. The order is latched at burst start.
- R7: With the order select high at burst start, the low two bits are start XOR k.
- R8: The fifth address of a burst equals the first. The upper address bits stay at the loaded value during a burst.
- R9: With both strobes high and advance high, address, command and strobes of the running burst keep their address and command.
- R10: Global write low gives strobes all ones. Otherwise byte write low gives strobe i = NOT lane enable i (bit i of the lane input, active low). Both high is a read. Byte write low with no lane enabled starts a read. Strobes are nonzero only with command WRITE.
- R11: Step and pause cycles keep the read/write type chosen at burst start. Write inputs during a read burst have no effect. Strobes are re-evaluated from the current write inputs on every write-burst cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | External address |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary chip select, active low |
| sel_hi | input | 1 | Secondary chip select, active high |
| sel_lo_n | input | 1 | Secondary chip select, active low |
| all_wr_n | input | 1 | Global write, active low |
| byte_wr_n | input | 1 | Byte write qualifier, active low |
| lane_en_n | input | LANES | Per-byte write enables, active low |
| ilv_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| arr_addr | output | ADDR_W | Array address |
| arr_cmd | output | 2 | 0 IDLE, 1 READ, 2 WRITE |
| arr_wstb | output | LANES | Per-byte write strobes |

## Verification
The hardest situation to reach is one where the strobe precedence and the stored burst type interact. Examples are a masked processor strobe arriving during a write burst, advance cycles after a deselect, and a processor strobe that overrides a controller write in the same cycle. The stimulus builds a write burst with the controller strobe, then drives the processor strobe with the primary select high. It then deselects, advances with no burst open, and finally drives both strobes low with global write asserted. Wrap-around and the interleaved order are covered by running full five-step bursts from non-zero start offsets.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } arr_cmd_e;

    typedef struct packed {
        logic start;   // load external address
        logic step;    // advance burst counter
        logic pause;   // hold current burst address
        logic drop;    // deselect
        logic wr;      // start is a write
    } cyc_class_t;

    localparam int CNT_W = 2;

    function automatic logic [CNT_W-1:0] burst_low(
        input logic [CNT_W-1:0] base,
        input logic [CNT_W-1:0] k,
        input logic             ilv
    );
        return ilv ? (base ^ k) : (base + k);
    endfunction

endpackage

// File: rtl/bfc_lanes.sv
module bfc_lanes #(
    parameter int LANES = 8
) (
    input  logic             all_wr_n,
    input  logic             byte_wr_n,
    input  logic [LANES-1:0] lane_en_n,
    output logic [LANES-1:0] lanes,
    output logic             any_lane
);
    always_comb begin
        if (!all_wr_n)       lanes = '1;
        else if (!byte_wr_n) lanes = ~lane_en_n;
        else                 lanes = '0;
        any_lane = |lanes;
    end
endmodule

// File: rtl/bfc_decode.sv
module bfc_decode
    import bfc_pkg::*;
(
    input  logic       cpu_strobe_n,
    input  logic       ctl_strobe_n,
    input  logic       adv_n,
    input  logic       sel_n,
    input  logic       sel_hi,
    input  logic       sel_lo_n,
    input  logic       any_lane,
    input  logic       burst_open,
    output cyc_class_t cls
);
    logic sec_ok;
    logic cpu_live;

    always_comb begin
        sec_ok   = sel_hi && !sel_lo_n;
        cpu_live = !cpu_strobe_n && !sel_n;
        cls      = '0;
        if (cpu_live) begin
            if (sec_ok) cls.start = 1'b1;
            else        cls.drop  = 1'b1;
        end else if (!ctl_strobe_n) begin
            if (sel_n || !sec_ok) begin
                cls.drop = 1'b1;
            end else begin
                cls.start = 1'b1;
                cls.wr    = any_lane;
            end
        end else if (burst_open) begin
            if (adv_n) cls.pause = 1'b1;
            else       cls.step  = 1'b1;
        end
    end
endmodule

// File: rtl/bfc_counter.sv
module bfc_counter
    import bfc_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ilv_order,
    input  logic              load,
    input  logic              adv,
    input  logic              hold,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int UP_W = ADDR_W - CNT_W;

    logic [UP_W-1:0]  upper_q;
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] k_q;
    logic             ilv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            base_q  <= '0;
            k_q     <= '0;
            ilv_q   <= 1'b0;
        end else if (load) begin
            upper_q <= ext_addr[ADDR_W-1:CNT_W];
            base_q  <= ext_addr[CNT_W-1:0];
            k_q     <= '0;
            ilv_q   <= ilv_order;
        end else if (adv) begin
            k_q <= k_q + 1'b1;
        end
    end

    assign addr_o = {upper_q, burst_low(base_q, k_q, ilv_q)};

    assert_pause_hold_R9: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(addr_o));

    assert_upper_kept_R8: assert property (@(posedge clk) disable iff (rst)
        adv |=> addr_o[ADDR_W-1:CNT_W] == $past(addr_o[ADDR_W-1:CNT_W]));

    assert_step_moves_R6: assert property (@(posedge clk) disable iff (rst)
        adv |=> addr_o[CNT_W-1:0] != $past(addr_o[CNT_W-1:0]));
endmodule

// File: rtl/burst_front_ctrl.sv
module burst_front_ctrl
    import bfc_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              cpu_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              adv_n,
    input  logic              sel_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              all_wr_n,
    input  logic              byte_wr_n,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic              ilv_order,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [1:0]        arr_cmd,
    output logic [LANES-1:0]  arr_wstb
);
    logic [LANES-1:0] lanes;
    logic             any_lane;
    cyc_class_t       cls;
    logic             open_q;
    arr_cmd_e         type_q;
    arr_cmd_e         cmd_q;
    arr_cmd_e         cmd_d;
    logic [LANES-1:0] wstb_q;

    bfc_lanes #(.LANES(LANES)) u_lanes (
        .all_wr_n (all_wr_n),
        .byte_wr_n(byte_wr_n),
        .lane_en_n(lane_en_n),
        .lanes    (lanes),
        .any_lane (any_lane)
    );

    bfc_decode u_decode (
        .cpu_strobe_n(cpu_strobe_n),
        .ctl_strobe_n(ctl_strobe_n),
        .adv_n       (adv_n),
        .sel_n       (sel_n),
        .sel_hi      (sel_hi),
        .sel_lo_n    (sel_lo_n),
        .any_lane    (any_lane),
        .burst_open  (open_q),
        .cls         (cls)
    );

    bfc_counter #(.ADDR_W(ADDR_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .ext_addr (ext_addr),
        .ilv_order(ilv_order),
        .load     (cls.start),
        .adv      (cls.step),
        .hold     (cls.pause),
        .addr_o   (arr_addr)
    );

    always_comb begin
        if (cls.start)                  cmd_d = cls.wr ? CMD_WRITE : CMD_READ;
        else if (cls.step || cls.pause) cmd_d = type_q;
        else                            cmd_d = CMD_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            type_q <= CMD_READ;
            cmd_q  <= CMD_IDLE;
            wstb_q <= '0;
        end else begin
            if (cls.start) begin
                open_q <= 1'b1;
                type_q <= cmd_d;
            end else if (cls.drop) begin
                open_q <= 1'b0;
            end
            cmd_q  <= cmd_d;
            wstb_q <= (cmd_d == CMD_WRITE) ? lanes : '0;
        end
    end

    assign arr_cmd  = cmd_q;
    assign arr_wstb = wstb_q;

    assert_cpu_reads_R2: assert property (@(posedge clk) disable iff (rst)
        (!cpu_strobe_n && !sel_n && sel_hi && !sel_lo_n)
        |=> (arr_cmd == CMD_READ && arr_wstb == '0 && arr_addr == $past(ext_addr)));

    assert_ctl_desel_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctl_strobe_n && sel_n) |=> arr_cmd == CMD_IDLE);

    assert_strobe_needs_write_R10: assert property (@(posedge clk) disable iff (rst)
        (arr_cmd != CMD_WRITE) |-> arr_wstb == '0);

    assert_pause_keeps_cmd_R11: assert property (@(posedge clk) disable iff (rst)
        (cls.pause || cls.step) |=> arr_cmd == $past(arr_cmd));
endmodule

// File: tb/burst_front_ctrl_bench.sv
module burst_front_ctrl_bench;
    localparam int AW = 18;
    localparam int NB = 8;

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    cmd;
        logic [NB-1:0] wstb;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, adv_n = 1'b1;
    logic          sel_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
    logic          all_wr_n = 1'b1, byte_wr_n = 1'b1, ilv_order = 1'b0;
    logic [NB-1:0] lane_en_n = '1;
    logic [AW-1:0] arr_addr;
    logic [1:0]    arr_cmd;
    logic [NB-1:0] arr_wstb;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    burst_front_ctrl #(.ADDR_W(AW), .LANES(NB)) u_burst_front_ctrl (
        .clk(clk), .rst(rst), .ext_addr(ext_addr),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .adv_n(adv_n),
        .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_en_n(lane_en_n),
        .ilv_order(ilv_order),
        .arr_addr(arr_addr), .arr_cmd(arr_cmd), .arr_wstb(arr_wstb)
    );

    task automatic check(string tag, logic [AW-1:0] ea, logic [1:0] ec, logic [NB-1:0] ew);
        checks++;
        if (arr_addr !== ea || arr_cmd !== ec || arr_wstb !== ew) begin
            failures++;
            $display("FAIL %s: addr=%h cmd=%0d wstb=%h expected addr=%h cmd=%0d wstb=%h",
                     tag, arr_addr, arr_cmd, arr_wstb, ea, ec, ew);
        end
    endtask

    // monitor: compares one scoreboard item per clock, away from the edge
    always begin
        @(posedge clk);
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, e.addr, e.cmd, e.wstb);
        end
    end

    task automatic drv(
        logic cpu, logic ctl, logic adv, logic sn, logic shi, logic slo,
        logic gw, logic bw, logic [NB-1:0] be, logic ilv, logic [AW-1:0] a,
        logic [AW-1:0] ea, logic [1:0] ec, logic [NB-1:0] ew, string tag);
        exp_t e;
        @(negedge clk);
        cpu_strobe_n = cpu; ctl_strobe_n = ctl; adv_n = adv;
        sel_n = sn; sel_hi = shi; sel_lo_n = slo;
        all_wr_n = gw; byte_wr_n = bw; lane_en_n = be;
        ilv_order = ilv; ext_addr = a;
        e.addr = ea; e.cmd = ec; e.wstb = ew; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", '0, 2'd0, '0);
        rst = 1'b0;
        // R2: processor strobe read, write inputs ignored
        drv(0,1,1, 0,1,0, 0,1,8'hFF, 0, 18'h12345, 18'h12345, 2'd1, 8'h00, "R2 cpu start");
        // R6 linear steps, R8 wrap
        drv(1,1,0, 0,1,0, 1,1,8'hFF, 0, 18'h0,     18'h12346, 2'd1, 8'h00, "R6 linear k1");
        drv(1,1,0, 0,1,0, 1,1,8'hFF, 0, 18'h0,     18'h12347, 2'd1, 8'h00, "R6 linear k2");
        drv(1,1,0, 0,1,0, 1,1,8'hFF, 0, 18'h0,     18'h12344, 2'd1, 8'h00, "R6 linear k3");
        drv(1,1,0, 0,1,0, 1,1,8'hFF, 0, 18'h0,     18'h12345, 2'd1, 8'h00, "R8 linear wrap");
        drv(1,1,1, 0,1,0, 1,1,8'hFF, 0, 18'h0,     18'h12345, 2'd1, 8'h00, "R9 pause");
        drv(1,1,0, 0,1,0, 1,0,8'h00, 0, 18'h0,     18'h12346, 2'd1, 8'h00, "R11 read burst ignores write inputs");
        // R4 controller write, R10 byte lanes
        drv(1,0,1, 0,1,0, 1,0,8'hF0, 1, 18'h00A02, 18'h00A02, 2'd2, 8'h0F, "R4 ctl write start");
        drv(1,1,0, 0,1,0, 0,1,8'hFF, 1, 18'h0,     18'h00A03, 2'd2, 8'hFF, "R7 interleave k1");
        drv(1,1,0, 0,1,0, 1,1,8'hFF, 1, 18'h0,     18'h00A00, 2'd2, 8'h00, "R11 write type kept");
        drv(1,1,0, 0,1,0, 1,0,8'hFE, 1, 18'h0,     18'h00A01, 2'd2, 8'h01, "R7 interleave k3");
        drv(1,1,0, 0,1,0, 1,0,8'hFE, 1, 18'h0,     18'h00A02, 2'd2, 8'h01, "R8 interleave wrap");
        // R3 masked processor strobe acts as pause
        drv(0,1,1, 1,1,0, 1,1,8'hFF, 0, 18'h3FFFF, 18'h00A02, 2'd2, 8'h00, "R3 masked cpu strobe");
        // R5 deselects
        drv(0,0,1, 1,1,0, 1,1,8'hFF, 0, 18'h3FFFF, 18'h00A02, 2'd0, 8'h00, "R5 ctl with primary high");
        drv(1,1,0, 0,1,0, 1,1,8'hFF, 0, 18'h0,     18'h00A02, 2'd0, 8'h00, "R5 advance after deselect");
        drv(0,1,1, 0,0,0, 1,1,8'hFF, 0, 18'h3FFFF, 18'h00A02, 2'd0, 8'h00, "R5 secondary false");
        drv(1,0,1, 0,1,0, 1,0,8'hFF, 0, 18'h2000F, 18'h2000F, 2'd1, 8'h00, "R10 no lane is read");
        drv(1,1,0, 0,0,0, 1,1,8'hFF, 0, 18'h0,     18'h2000C, 2'd1, 8'h00, "R5 secondary ignored on step");
        drv(1,0,1, 0,1,1, 1,1,8'hFF, 0, 18'h3FFFF, 18'h2000C, 2'd0, 8'h00, "R5 low secondary false");
        drv(1,0,1, 0,1,0, 0,1,8'hFF, 1, 18'h15551, 18'h15551, 2'd2, 8'hFF, "R10 global write");
        drv(0,0,1, 0,1,0, 0,1,8'hFF, 0, 18'h00003, 18'h00003, 2'd1, 8'h00, "R2 cpu beats ctl write");
        drv(1,1,0, 0,1,0, 1,1,8'hFF, 1, 18'h0,     18'h00000, 2'd1, 8'h00, "R6 order latched");
        drv(1,1,1, 0,1,0, 1,1,8'hFF, 0, 18'h0,     18'h00000, 2'd1, 8'h00, "R9 pause again");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule